// File: doc/BRIEF.md
# MMU access permission checker

This block makes the final allow-or-fault decision for a memory access once the table walk has produced the descriptor fields. It takes the two-bit domain access value, the mapping kind (section, large page, small page or tiny page), the level-one AP field, the four level-two AP sub-fields, the two address-bit pairs that can pick a quarter of a page, the privileged and write flags, and the two protection control bits (system and ROM). It reports whether the access is allowed. If it is not, it reports the class of fault.

The domain value is examined first. A manager domain grants every access without any AP check. A client domain sends the access through the AP decode. The no-access domain code and the reserved domain code both raise a domain fault. For large and small pages, one of four AP sub-fields is chosen by the quarter of the page being accessed. Sections and tiny pages use the level-one AP field instead.

A denial on a section is reported as a section permission fault. A denial on any kind of page is reported as a page permission fault. The inputs are captured on a cycle with `in_valid` high. The result appears on the next clock edge, qualified by `out_valid`.

Top module: `mmu_perm_check`

## Requirements
- R1: While `rst` is high, after a clock edge `out_valid`, `allow` and `fault_valid` are 0 and `fault_kind` is 2'b00.
- R2: `out_valid` equals the `in_valid` of the previous cycle. When `out_valid` is 0, `allow` and `fault_valid` are 0 and `fault_kind` is 2'b00 (none).
- R3: Domain 2'b00 (no access) and domain 2'b10 (reserved) deny the access with `fault_kind` 2'b11 (domain fault), whatever the AP bits are.
- R4: Domain 2'b11 (manager) allows every access with `fault_kind` 2'b00, whatever the AP bits and control bits are.
- R5: Under domain 2'b01 (client), the AP codes decode as follows. AP 2'b11 allows everything. AP 2'b10 allows privileged read and write, and user read only. AP 2'b01 allows privileged read and write and no user access.
- R6: Under a client domain, AP 2'b00 decodes as follows. With system=1 and ROM=0 it allows privileged read only. With system=0 and ROM=1 it allows reads in both modes. With system and ROM both 0, or both 1, it denies everything.
- R7: `map_kind` 2'b00 is a section. A section checks `l1_ap`, and a denial gives `fault_kind` 2'b01 (section permission).
- R8: `map_kind` 2'b10 is a small page. It checks `l2_ap[2*q+1:2*q]`, where q is `va_small_q` (virtual address bits 11:10). A denial gives `fault_kind` 2'b10 (page permission).
- R9: `map_kind` 2'b01 is a large page. It checks `l2_ap[2*q+1:2*q]`, where q is `va_large_q` (virtual address bits 15:14). A denial gives `fault_kind` 2'b10.
- R10: `map_kind` 2'b11 is a tiny page. It checks `l1_ap` and ignores `l2_ap`. A denial gives `fault_kind` 2'b10.
- R11: When `out_valid` is 1, exactly one of `allow` and `fault_valid` is 1. `fault_kind` is nonzero exactly when `fault_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid; the inputs are captured on this cycle |
| dom | input | 2 | Domain access value: 00 none, 01 client, 10 reserved, 11 manager |
| map_kind | input | 2 | Mapping kind: 00 section, 01 large page, 10 small page, 11 tiny page |
| l1_ap | input | 2 | AP field of the level-one descriptor |
| l2_ap | input | 8 | Four AP sub-fields; bits [1:0] cover the lowest quarter and bits [7:6] the highest |
| va_small_q | input | 2 | Virtual address bits 11:10 |
| va_large_q | input | 2 | Virtual address bits 15:14 |
| priv | input | 1 | Access made in privileged mode |
| wr | input | 1 | Access is a write |
| sys_prot | input | 1 | System protection control bit |
| rom_prot | input | 1 | ROM protection control bit |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| allow | output | 1 | Access granted |
| fault_valid | output | 1 | Access denied |
| fault_kind | output | 2 | 00 none, 01 section permission, 10 page permission, 11 domain |

## Verification
The bench sweeps every AP code against every combination of the system and ROM bits, privilege and direction. A decode with a swapped case in the AP=00 row would grant a user write or refuse a legal read. Each page test fills the four sub-fields with different codes and gives the two quarter selectors conflicting values. A design that picked the wrong address pair, or reversed the order of the sub-fields, would then allow the wrong quarter. Tiny pages are given permissive level-two fields and a restrictive level-one field, so a checker that used the level-two fields would wrongly grant. The reserved and manager domain codes are paired with AP values that would give the opposite answer, so a skipped domain check shows up as a wrong grant or a wrong fault class.

// File: rtl/mmu_perm_check.sv
module mmu_perm_check (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [1:0] dom,
  input  logic [1:0] map_kind,
  input  logic [1:0] l1_ap,
  input  logic [7:0] l2_ap,
  input  logic [1:0] va_small_q,
  input  logic [1:0] va_large_q,
  input  logic       priv,
  input  logic       wr,
  input  logic       sys_prot,
  input  logic       rom_prot,
  output logic       out_valid,
  output logic       allow,
  output logic       fault_valid,
  output logic [1:0] fault_kind
);
  localparam logic [1:0] MAP_SECTION = 2'b00;
  localparam logic [1:0] MAP_LARGE   = 2'b01;
  localparam logic [1:0] MAP_SMALL   = 2'b10;
  localparam logic [1:0] DOM_CLIENT  = 2'b01;
  localparam logic [1:0] DOM_MANAGER = 2'b11;
  localparam logic [1:0] FK_NONE     = 2'b00;
  localparam logic [1:0] FK_SECTION  = 2'b01;
  localparam logic [1:0] FK_PAGE     = 2'b10;
  localparam logic [1:0] FK_DOMAIN   = 2'b11;

  logic [1:0] quarter, sub_ap, eff_ap, kind_n;
  logic       use_sub, ap_ok, is_client, is_manager, grant;

  assign quarter    = (map_kind == MAP_LARGE) ? va_large_q : va_small_q;
  assign sub_ap     = l2_ap[{quarter, 1'b0} +: 2];
  assign use_sub    = (map_kind == MAP_LARGE) || (map_kind == MAP_SMALL);
  assign eff_ap     = use_sub ? sub_ap : l1_ap;
  assign is_client  = (dom == DOM_CLIENT);
  assign is_manager = (dom == DOM_MANAGER);

  always_comb begin
    case (eff_ap)
      2'b11:   ap_ok = 1'b1;
      2'b10:   ap_ok = priv | ~wr;
      2'b01:   ap_ok = priv;
      default: case ({sys_prot, rom_prot})
                 2'b10:   ap_ok = priv & ~wr;
                 2'b01:   ap_ok = ~wr;
                 default: ap_ok = 1'b0;
               endcase
    endcase
  end

  assign grant  = is_manager | (is_client & ap_ok);
  assign kind_n = grant      ? FK_NONE :
                  !is_client ? FK_DOMAIN :
                  (map_kind == MAP_SECTION) ? FK_SECTION : FK_PAGE;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      allow       <= 1'b0;
      fault_valid <= 1'b0;
      fault_kind  <= FK_NONE;
    end else begin
      out_valid   <= in_valid;
      allow       <= in_valid & grant;
      fault_valid <= in_valid & ~grant;
      fault_kind  <= in_valid ? kind_n : FK_NONE;
    end
  end
endmodule

module mmu_perm_check_sva (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [1:0] dom,
  input logic       out_valid,
  input logic       allow,
  input logic       fault_valid,
  input logic [1:0] fault_kind
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !allow && !fault_valid && fault_kind == 2'b00));
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !allow && !fault_valid && fault_kind == 2'b00));
  assert_domain_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (dom == 2'b00 || dom == 2'b10)) |=> (fault_valid && fault_kind == 2'b11));
  assert_manager_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dom == 2'b11) |=> (allow && fault_kind == 2'b00));
  assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({allow, fault_valid}) == 1);
  assert_kind_matches_R11: assert property (@(posedge clk) disable iff (rst)
    fault_valid == (fault_kind != 2'b00));
endmodule

bind mmu_perm_check mmu_perm_check_sva sva_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dom(dom),
  .out_valid(out_valid), .allow(allow), .fault_valid(fault_valid),
  .fault_kind(fault_kind)
);

// File: tb/mmu_perm_check_tb.sv
module mmu_perm_check_tb_top;
  logic clk = 1'b0;
  logic rst, in_valid, priv, wr, sys_prot, rom_prot;
  logic [1:0] dom, map_kind, l1_ap, va_small_q, va_large_q;
  logic [7:0] l2_ap;
  logic out_valid, allow, fault_valid;
  logic [1:0] fault_kind;
  int n_checks = 0, n_fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mmu_perm_check dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dom(dom), .map_kind(map_kind),
    .l1_ap(l1_ap), .l2_ap(l2_ap), .va_small_q(va_small_q), .va_large_q(va_large_q),
    .priv(priv), .wr(wr), .sys_prot(sys_prot), .rom_prot(rom_prot),
    .out_valid(out_valid), .allow(allow), .fault_valid(fault_valid),
    .fault_kind(fault_kind)
  );

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  function automatic bit ap_rule(logic [1:0] ap, bit s, bit r, bit p, bit w);
    if (ap == 2'b11) return 1;
    if (ap == 2'b10) return p || !w;
    if (ap == 2'b01) return p;
    if (s && !r) return p && !w;
    if (!s && r) return !w;
    return 0;
  endfunction

  // expected {allow, fault_valid, fault_kind}
  function automatic logic [3:0] expect_of();
    logic [1:0] ap;
    bit ok;
    if (dom == 2'b11) return 4'b1000;
    if (dom != 2'b01) return 4'b0111;
    case (map_kind)
      2'b01:   ap = l2_ap[2*va_large_q +: 2];
      2'b10:   ap = l2_ap[2*va_small_q +: 2];
      default: ap = l1_ap;
    endcase
    ok = ap_rule(ap, sys_prot, rom_prot, priv, wr);
    if (ok) return 4'b1000;
    return (map_kind == 2'b00) ? 4'b0101 : 4'b0110;
  endfunction

  task automatic access(string tag);
    logic [3:0] exp;
    @(negedge clk);
    in_valid = 1;
    exp = expect_of();
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid"}, {3'b0, out_valid}, 4'b0001);
    check(tag, {allow, fault_valid, fault_kind}, exp);
  endtask

  task automatic t_reset();
    rst = 1; in_valid = 1; dom = 2'b11;
    repeat (2) @(negedge clk);
    check("R1 reset", {out_valid, allow, fault_valid, fault_kind[0]}, 4'b0000);
    check("R1 reset kind", {2'b0, fault_kind}, 4'b0000);
    rst = 0; in_valid = 0;
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 0; dom = 2'b11;
    @(negedge clk);
    check("R2 idle", {out_valid, allow, fault_valid, 1'b0}, 4'b0000);
    check("R2 idle kind", {2'b0, fault_kind}, 4'b0000);
  endtask

  task automatic t_domain();
    map_kind = 2'b00; l1_ap = 2'b11; priv = 1; wr = 0; sys_prot = 0; rom_prot = 0;
    dom = 2'b00; access("R3 domain none");
    dom = 2'b10; access("R3 domain reserved");
    map_kind = 2'b10; l2_ap = 8'hFF; access("R3 domain reserved page");
  endtask

  task automatic t_manager();
    dom = 2'b11; map_kind = 2'b00; l1_ap = 2'b00; sys_prot = 0; rom_prot = 0;
    priv = 0; wr = 1; access("R4 manager section");
    map_kind = 2'b01; l2_ap = 8'h00; access("R4 manager page");
  endtask

  task automatic t_section_sweep();
    dom = 2'b01; map_kind = 2'b00;
    for (int i = 0; i < 64; i++) begin
      {l1_ap, sys_prot, rom_prot, priv, wr} = i[5:0];
      access((l1_ap == 2'b00) ? "R6 R7 section ap00" : "R5 R7 section ap");
    end
    l1_ap = 2'b01; priv = 0; wr = 0; access("R5 R7 user denied");
    check("R7 section fault kind", {2'b0, fault_kind}, 4'b0001);
  endtask

  task automatic t_small();
    dom = 2'b01; map_kind = 2'b10; l2_ap = 8'b11_10_01_00; l1_ap = 2'b11;
    sys_prot = 0; rom_prot = 0; priv = 0; wr = 1;
    for (int q = 0; q < 4; q++) begin
      va_small_q = q[1:0]; va_large_q = ~q[1:0];
      access("R8 small quarter");
    end
    priv = 0; wr = 0;
    for (int q = 0; q < 4; q++) begin
      va_small_q = q[1:0]; va_large_q = 2'b11;
      access("R8 small quarter read");
    end
  endtask

  task automatic t_large();
    dom = 2'b01; map_kind = 2'b01; l2_ap = 8'b00_01_10_11; l1_ap = 2'b11;
    sys_prot = 1; rom_prot = 0; priv = 0; wr = 0;
    for (int q = 0; q < 4; q++) begin
      va_large_q = q[1:0]; va_small_q = ~q[1:0];
      access("R9 large quarter");
    end
    va_large_q = 2'b11; priv = 1; wr = 1; access("R9 large top quarter");
    check("R9 large fault kind", {2'b0, fault_kind}, 4'b0010);
  endtask

  task automatic t_tiny();
    dom = 2'b01; map_kind = 2'b11; l2_ap = 8'hFF; va_small_q = 0; va_large_q = 0;
    sys_prot = 0; rom_prot = 0; priv = 1; wr = 0;
    l1_ap = 2'b00; access("R10 tiny denied");
    check("R10 tiny page fault", {2'b0, fault_kind}, 4'b0010);
    l1_ap = 2'b10; priv = 0; wr = 1; access("R10 tiny user write");
    wr = 0; access("R10 tiny user read");
  endtask

  initial begin
    in_valid = 0; priv = 0; wr = 0; sys_prot = 0; rom_prot = 0;
    dom = 0; map_kind = 0; l1_ap = 0; l2_ap = 0; va_small_q = 0; va_large_q = 0;
    t_reset();
    t_idle();
    t_domain();
    t_manager();
    t_section_sweep();
    t_small();
    t_large();
    t_tiny();
    t_idle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog got=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule